// File: doc/BRIEF.md
# Saturating Signed Adder

This block adds two signed two's-complement operands of a parameterised width and returns the result, a signed-overflow flag, and a flag that reports when clamping was applied. A single mode input selects the behaviour on overflow. In wrap mode the low bits of the sum are returned unchanged. In clamp mode a sum that leaves the representable range is pinned to the nearest end of that range.

The overflow flag comes from the carry chain: it is the exclusive-OR of the carry entering the sign position and the carry leaving it. That flag is expanded into a mask that picks, bit by bit, between the raw sum and the boundary value. No magnitude comparison against the limits is made. The boundary value depends only on the sign of operand A, because overflow can only happen when both operands share that sign. By default one register stage sits on all outputs. It can be removed with a parameter to give a purely combinational path.

Top module: `sat_add`

## Requirements
- R1: With `mode_sat` = 0 (wrap), `sum_out` equals (`op_a` + `op_b`) modulo 2^W. For example, at W = 8, 127 + 1 returns -128 (0x80).
- R2: `ovf_out` is 1 exactly when the true signed sum lies outside [-2^(W-1), 2^(W-1)-1]. It is reported the same way in both modes.
- R3: With `mode_sat` = 1, an overflow with two non-negative operands gives `sum_out` = 2^(W-1)-1, which is 0x7F at W = 8.
- R4: With `mode_sat` = 1, an overflow with two negative operands gives `sum_out` = -2^(W-1), which is 0x80 at W = 8.
- R5: With `mode_sat` = 1 and no overflow, `sum_out` equals the exact signed sum.
- R6: `sat_hit_out` is 1 exactly when `ovf_out` is 1 and the vector was presented with `mode_sat` = 1.
- R7: With `OUT_REG` = 1 (the default), each output reflects the inputs sampled at the previous rising edge of `clk`. Changing the inputs does not change the outputs before the next edge.
- R8: While `rst_n` is low, `sum_out`, `ovf_out` and `sat_hit_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| mode_sat | input | 1 | 0 = wrap-around, 1 = clamp on overflow |
| op_a | input | W | Signed operand A; its sign selects the clamp boundary |
| op_b | input | W | Signed operand B |
| sum_out | output | W | Signed result |
| ovf_out | output | 1 | Signed overflow of the addition |
| sat_hit_out | output | 1 | Overflow occurred and clamping replaced the sum |

## Verification
Overflow detection and clamping can fall in the same cycle. So can overflow detection and a plain wrapped result. The bench provokes both by sending the same overflowing operand pairs twice, once in each mode: 127 + 1, -76 + -102, -128 + -128 and 127 + 127. It then checks that the flag stays the same while only the result and the clamp indicator change. Near-boundary sums that do not overflow are also sent in clamp mode, for example -100 + -28 and -128 + 127. These show that clamping triggers only on a real range violation. A long pseudo-random run, with the mode alternating every vector, is compared each cycle against an integer reference model that assumes one cycle of latency.

// File: rtl/sat_add_pkg.sv
package sat_add_pkg;

    typedef enum logic {
        ADD_WRAP  = 1'b0,
        ADD_CLAMP = 1'b1
    } add_mode_e;

endpackage

// File: rtl/sat_add_ripple.sv
module sat_add_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s,
    output logic         c_msb_in,
    output logic         c_msb_out
);
    logic [W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]       = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign c_msb_in  = carry[W-1];
    assign c_msb_out = carry[W];
endmodule

// File: rtl/sat_add_clamp.sv
module sat_add_clamp
    import sat_add_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] raw_sum,
    input  logic         a_sign,
    input  logic         c_msb_in,
    input  logic         c_msb_out,
    input  add_mode_e    mode,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         hit
);
    logic [W-1:0] bound;
    logic [W-1:0] pick;

    always_comb begin
        ovf   = c_msb_in ^ c_msb_out;
        hit   = ovf & (mode == ADD_CLAMP);
        bound = {a_sign, {(W-1){~a_sign}}};
        pick  = {W{hit}};
        res   = (raw_sum & ~pick) | (bound & pick);
    end
endmodule

// File: rtl/sat_add_stage.sv
module sat_add_stage #(
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_sum,
    input  logic         d_ovf,
    input  logic         d_hit,
    output logic [W-1:0] q_sum,
    output logic         q_ovf,
    output logic         q_hit
);
    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_sum <= '0;
                q_ovf <= 1'b0;
                q_hit <= 1'b0;
            end else begin
                q_sum <= d_sum;
                q_ovf <= d_ovf;
                q_hit <= d_hit;
            end
        end
    end else begin : g_comb
        assign q_sum = rst_n ? d_sum : '0;
        assign q_ovf = rst_n & d_ovf;
        assign q_hit = rst_n & d_hit;
    end
endmodule

// File: rtl/sat_add.sv
module sat_add
    import sat_add_pkg::*;
#(
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_sat,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum_out,
    output logic         ovf_out,
    output logic         sat_hit_out
);
    localparam int MSB = W - 1;

    logic [W-1:0] raw_sum;
    logic         c_in_top;
    logic         c_out_top;
    logic [W-1:0] sel_sum;
    logic         ovf_c;
    logic         hit_c;
    add_mode_e    mode;

    assign mode = add_mode_e'(mode_sat);

    sat_add_ripple #(.W(W)) u_adder (
        .a         (op_a),
        .b         (op_b),
        .s         (raw_sum),
        .c_msb_in  (c_in_top),
        .c_msb_out (c_out_top)
    );

    sat_add_clamp #(.W(W)) u_clamp (
        .raw_sum   (raw_sum),
        .a_sign    (op_a[MSB]),
        .c_msb_in  (c_in_top),
        .c_msb_out (c_out_top),
        .mode      (mode),
        .res       (sel_sum),
        .ovf       (ovf_c),
        .hit       (hit_c)
    );

    sat_add_stage #(.W(W), .OUT_REG(OUT_REG)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d_sum (sel_sum),
        .d_ovf (ovf_c),
        .d_hit (hit_c),
        .q_sum (sum_out),
        .q_ovf (ovf_out),
        .q_hit (sat_hit_out)
    );
endmodule

// File: rtl/sat_add_checker.sv
module sat_add_checker #(
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_sat,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] sum_out,
    input logic         ovf_out,
    input logic         sat_hit_out
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] a_q, b_q;
    logic         m_q, ok_q;

    if (OUT_REG) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_q <= '0; b_q <= '0; m_q <= 1'b0; ok_q <= 1'b0;
            end else begin
                a_q <= op_a; b_q <= op_b; m_q <= mode_sat; ok_q <= 1'b1;
            end
        end
    end else begin : g_now
        assign a_q  = op_a;
        assign b_q  = op_b;
        assign m_q  = mode_sat;
        assign ok_q = rst_n;
    end

    logic signed [W+1:0] wide;
    logic                out_of_range;
    assign wide = $signed({{2{a_q[W-1]}}, a_q}) + $signed({{2{b_q[W-1]}}, b_q});
    assign out_of_range = (wide > $signed({2'b00, MAXV})) ||
                          (wide < $signed({2'b11, MINV}));

    // R1
    wrap_value_chk: assert property (@(posedge clk) disable iff (!rst_n || !ok_q)
        !m_q |-> sum_out == W'(a_q + b_q));
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n || !ok_q)
        ovf_out == out_of_range);
    // R3
    clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !ok_q)
        (m_q && out_of_range && !a_q[W-1]) |-> sum_out == MAXV);
    // R4
    clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n || !ok_q)
        (m_q && out_of_range && a_q[W-1]) |-> sum_out == MINV);
    // R5
    exact_sum_chk: assert property (@(posedge clk) disable iff (!rst_n || !ok_q)
        (m_q && !out_of_range) |-> sum_out == W'(a_q + b_q));
    // R6
    sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || !ok_q)
        sat_hit_out == (ovf_out && m_q));
    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (sum_out == '0 && !ovf_out && !sat_hit_out));
endmodule

bind sat_add sat_add_checker #(.W(W), .OUT_REG(OUT_REG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sat    (mode_sat),
    .op_a        (op_a),
    .op_b        (op_b),
    .sum_out     (sum_out),
    .ovf_out     (ovf_out),
    .sat_hit_out (sat_hit_out)
);

// File: tb/sat_add_test.sv
`timescale 1ns/1ps
module sat_add_test;
    localparam int W    = 8;
    localparam int MAXI = (1 << (W-1)) - 1;
    localparam int MINI = -(1 << (W-1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_sat = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] sum_out;
    logic         ovf_out;
    logic         sat_hit_out;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    int  exp_sum;
    bit  exp_ovf, exp_hit, exp_mode;
    bit  pend = 1'b0;

    always #4 clk = ~clk;

    sat_add #(.W(W), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sat(mode_sat),
        .op_a(op_a), .op_b(op_b),
        .sum_out(sum_out), .ovf_out(ovf_out), .sat_hit_out(sat_hit_out)
    );

    function automatic int to_int(input logic [W-1:0] v);
        return v[W-1] ? int'(v) - (1 << W) : int'(v);
    endfunction

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic check_pending();
        string tag;
        if (!pend) return;
        if (!exp_mode) tag = "R1";
        else if (exp_ovf) tag = (exp_sum > 0) ? "R3" : "R4";
        else tag = "R5";
        chk(tag, to_int(sum_out), exp_sum);
        chk("R2", int'(ovf_out), int'(exp_ovf));
        chk("R6", int'(sat_hit_out), int'(exp_hit));
    endtask

    // Drive at negedge; outputs for this vector appear after the next posedge.
    task automatic apply(input int a, input int b, input bit m);
        int s;
        @(negedge clk);
        check_pending();
        op_a = W'(a); op_b = W'(b); mode_sat = m;
        s = to_int(W'(a)) + to_int(W'(b));
        exp_ovf  = (s > MAXI) || (s < MINI);
        exp_mode = m;
        exp_hit  = exp_ovf && m;
        if (exp_hit) exp_sum = (s > 0) ? MAXI : MINI;
        else exp_sum = to_int(W'(s));
        pend = 1'b1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        op_a = 8'd100; op_b = 8'd100; mode_sat = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8", int'(sum_out), 0);
        chk("R8", int'(ovf_out), 0);
        chk("R8", int'(sat_hit_out), 0);
        rst_n = 1'b1;

        apply(127, 1, 1'b0);
        apply(127, 1, 1'b1);
        apply(-76, -102, 1'b0);
        apply(-76, -102, 1'b1);
        apply(-128, -128, 1'b0);
        apply(-128, -128, 1'b1);
        apply(127, 127, 1'b0);
        apply(127, 127, 1'b1);
        apply(-1, 1, 1'b1);
        apply(-100, -28, 1'b1);
        apply(-128, 127, 1'b1);
        apply(100, 27, 1'b1);
        apply(-128, -1, 1'b1);
        apply(0, 0, 1'b0);
        apply(50, 20, 1'b1);

        // R7: new inputs must not reach the outputs before the next edge
        @(negedge clk);
        check_pending();
        pend = 1'b0;
        op_a = 8'd5; op_b = 8'd3; mode_sat = 1'b0;
        #2;
        chk("R7", to_int(sum_out), 70);
        @(negedge clk);
        chk("R7", to_int(sum_out), 8);

        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            apply(int'(lfsr[7:0]), int'(lfsr[15:8]), i[0]);
        end
        @(negedge clk);
        check_pending();
        pend = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule